// File: doc/BRIEF.md
# Hardware Trap Prioritizer and Vectorer

This block sits beside a 16-bit CPU core and turns raised exception conditions into trap entries. Each hardware condition arrives as a one-cycle pulse. The pulse sets a dedicated bit in a trap flag register, and software clears that bit later through a masked clear write. The pulse also arms an internal pending bit. The pending bits are sorted into three priority levels. The winning level is compared with the level of the trap now in service, and a trap is taken only when the winner ranks strictly higher. Hardware traps cannot be masked.

When a trap is taken, the block pulses a take strobe for one cycle. On the same edge it presents the trap number and a vector address. The vector address carries a selectable segment in its upper bits and, in its lower 16 bits, the trap number times a spacing of 4, 8, 12 or 16 bytes. Software traps request any number from 0x00 to 0x7F. They run at the current level and set no flag. A return strobe restores the previous service level from a three-entry level stack. Conditions that were held back are then taken on the following cycle.

Top module: `trap_arbiter`

## Requirements
- R1: A pulse on `cond_i[k]` sets `flags_o[k]` on the next clock edge. The bit stays set until a write with `clr_we_i` high and `clr_mask_i[k]` high clears it. When a set and a clear hit the same bit in the same cycle, the set wins.
- R2: While `rst` is high, `take_o`, `num_o`, `vec_o`, `lvl_o` and `flags_o` are all zero. `lvl_o` encodes the service level as follows: 0 for no trap, 1 for class B, 2 for class A, 3 for reset request.
- R3: Each condition bit has a fixed trap number and level:
  - bit 0 (reset request): number 0x00, level 3.
  - bits 1 to 4 (system request 0, stack overflow, stack underflow, software break): numbers 0x02, 0x04, 0x06 and 0x08, level 2.
  - bits 5 to 9 (system request 1, undefined opcode, memory access error, protected instruction, illegal word operand): all share number 0x0A, level 1.
- R4: When several class-A conditions are pending together, the lowest bit (lowest trap number) is taken first. The others stay pending and are taken one by one as each service returns.
- R5: A hardware trap is taken only when its level is strictly above `lvl_o`. Otherwise it stays pending and is taken on the cycle after a return lowers `lvl_o` below its level. Taking a trap sets `lvl_o` to the trap's level.
- R6: A cycle with `ret_i` high takes no trap. It restores `lvl_o` to the level that was in service before the most recent hardware trap. With an empty level stack, `ret_i` leaves `lvl_o` unchanged.
- R7: A software trap (`swt_req_i` high, number `swt_num_i`) is taken when no hardware trap is taken that cycle and `ret_i` is low. It leaves `lvl_o` and `flags_o` unchanged. If a hardware trap is taken in the same cycle, or `ret_i` is high, the software request is dropped.
- R8: With a take, `vec_o` equals {`seg_i`, 16-bit offset}. The offset is the trap number times 4·(`spc_i`+1) bytes, so `spc_i` values 0 to 3 select a spacing of 4, 8, 12 or 16.
- R9: A condition or software request driven in one cycle raises `take_o` right after the next clock edge. `take_o` stays high for exactly one cycle per trap taken.
- R10: A single class-B take clears the pending state of every class-B condition pending at that moment. All of their flag bits stay set, so software can tell the causes apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | 10 | Hardware condition pulses, one bit per condition |
| clr_we_i | input | 1 | Flag clear write enable |
| clr_mask_i | input | 10 | Flag bits to clear |
| swt_req_i | input | 1 | Software trap request |
| swt_num_i | input | 7 | Software trap number |
| ret_i | input | 1 | Trap service return strobe |
| seg_i | input | 8 | Vector segment |
| spc_i | input | 2 | Vector spacing select |
| take_o | output | 1 | Trap taken (one-cycle pulse) |
| num_o | output | 7 | Trap number of the last take |
| vec_o | output | 24 | Vector address of the last take |
| lvl_o | output | 2 | Current service level |
| flags_o | output | 10 | Trap flag register |

## Verification
Each kind of wrong internal state shows up at the ports in its own way:
- A corrupted level stack shows up on the first return: `lvl_o` lands on the wrong level in the next cycle, and held conditions are either taken one cycle early or never taken at all.
- A pending bit that fails to clear shows up as an extra take on the cycle right after the matching return.
- A pending bit that is lost shows up as a missing take, which the scoreboard reports when it finds expected entries left over at the end.
- Wrong trap numbers or a wrong spacing show up on `num_o` and `vec_o` in the same cycle as the take.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int N_A    = 4;
  localparam int N_B    = 5;
  localparam int N_COND = 1 + N_A + N_B;
  localparam int NUM_W  = 7;
  localparam int LVL_W  = 2;

  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LV_IDLE = 2'd0;
  localparam lvl_t LV_B    = 2'd1;
  localparam lvl_t LV_A    = 2'd2;
  localparam lvl_t LV_RST  = 2'd3;

  localparam logic [NUM_W-1:0] NUM_RESET = 7'h00;
  localparam logic [NUM_W-1:0] NUM_CLS_B = 7'h0A;
endpackage

// File: rtl/trap_flags.sv
module trap_flags #(
  parameter int NC = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NC-1:0] set_i,
  input  logic          clr_we_i,
  input  logic [NC-1:0] clr_mask_i,
  input  logic [NC-1:0] take_clr_i,
  output logic [NC-1:0] flags_o,
  output logic [NC-1:0] pend_o
);
  logic [NC-1:0] flags_q, pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      pend_q  <= '0;
    end else begin
      flags_q <= (clr_we_i ? (flags_q & ~clr_mask_i) : flags_q) | set_i;
      pend_q  <= (pend_q | set_i) & ~take_clr_i;
    end
  end

  assign flags_o = flags_q;
  assign pend_o  = pend_q;
endmodule

// File: rtl/trap_pick.sv
module trap_pick
  import trap_pkg::*;
#(
  parameter int NA = 4,
  parameter int NB = 5
) (
  input  logic [NA+NB:0]   eff_i,
  output logic             hit_o,
  output lvl_t             lvl_o,
  output logic [NUM_W-1:0] num_o,
  output logic [NA+NB:0]   clr_o
);
  localparam int NC   = 1 + NA + NB;
  localparam int A_LO = 1;
  localparam int B_LO = 1 + NA;

  logic             a_hit, b_hit;
  logic [NA-1:0]    a_oh;
  logic [NUM_W-1:0] a_num;

  // lowest class-A index wins
  always_comb begin
    a_hit = 1'b0;
    a_oh  = '0;
    a_num = '0;
    for (int i = 0; i < NA; i++) begin
      if (eff_i[A_LO+i] && !a_hit) begin
        a_hit   = 1'b1;
        a_oh[i] = 1'b1;
        a_num   = NUM_W'(2 * (i + 1));
      end
    end
  end

  assign b_hit = |eff_i[B_LO +: NB];

  always_comb begin
    hit_o = 1'b0;
    lvl_o = LV_IDLE;
    num_o = '0;
    clr_o = '0;
    if (eff_i[0]) begin
      hit_o    = 1'b1;
      lvl_o    = LV_RST;
      num_o    = NUM_RESET;
      clr_o[0] = 1'b1;
    end else if (a_hit) begin
      hit_o            = 1'b1;
      lvl_o            = LV_A;
      num_o            = a_num;
      clr_o[A_LO +: NA] = a_oh;
    end else if (b_hit) begin
      hit_o            = 1'b1;
      lvl_o            = LV_B;
      num_o            = NUM_CLS_B;
      clr_o[B_LO +: NB] = {NB{1'b1}};
    end
  end

  logic unused_nc;
  assign unused_nc = (NC == 0);
endmodule

// File: rtl/lvl_stack.sv
module lvl_stack #(
  parameter int DEPTH = 3,
  parameter int W     = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o,
  output logic         empty_o
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]   mem [DEPTH];
  logic [SPW-1:0] sp;
  logic [SPW-1:0] sp_m1;
  logic           full;

  assign full    = (sp == SPW'(DEPTH));
  assign empty_o = (sp == '0);
  assign sp_m1   = sp - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) sp <= '0;
    else if (push_i && !full) sp <= sp + 1'b1;
    else if (pop_i && !empty_o) sp <= sp_m1;
  end

  always_ff @(posedge clk) begin
    if (push_i && !full) mem[sp[IW-1:0]] <= din_i;
  end

  assign top_o = mem[sp_m1[IW-1:0]];
endmodule

// File: rtl/vec_calc.sv
module vec_calc #(
  parameter int NUM_W = 7,
  parameter int OFF_W = 16,
  parameter int UNIT_SH = 2
) (
  input  logic [NUM_W-1:0] num_i,
  input  logic [1:0]       spc_i,
  output logic [OFF_W-1:0] off_o
);
  logic [OFF_W-1:0] n, m;

  assign n = OFF_W'(num_i);

  // num * (spc+1) with shifts and one add
  always_comb begin
    case (spc_i)
      2'd0:    m = n;
      2'd1:    m = n << 1;
      2'd2:    m = n + (n << 1);
      default: m = n << 2;
    endcase
  end

  assign off_o = m << UNIT_SH;
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
#(
  parameter int SEG_W     = 8,
  parameter int OFF_W     = 16,
  parameter int STK_DEPTH = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_COND-1:0]      cond_i,
  input  logic                   clr_we_i,
  input  logic [N_COND-1:0]      clr_mask_i,
  input  logic                   swt_req_i,
  input  logic [NUM_W-1:0]       swt_num_i,
  input  logic                   ret_i,
  input  logic [SEG_W-1:0]       seg_i,
  input  logic [1:0]             spc_i,
  output logic                   take_o,
  output logic [NUM_W-1:0]       num_o,
  output logic [SEG_W+OFF_W-1:0] vec_o,
  output logic [LVL_W-1:0]       lvl_o,
  output logic [N_COND-1:0]      flags_o
);
  localparam int AW = SEG_W + OFF_W;

  logic [N_COND-1:0] pend, eff, pick_clr, take_clr;
  logic              pick_hit, hw_go, sw_go, pop, stk_empty;
  lvl_t              pick_lvl, cur_lvl, stk_top;
  logic [NUM_W-1:0]  pick_num, sel_num;
  logic [OFF_W-1:0]  off;

  logic              take_q;
  logic [NUM_W-1:0]  num_q;
  logic [AW-1:0]     vec_q;

  assign eff = pend | cond_i;

  trap_flags #(.NC(N_COND)) u_flags (
    .clk(clk), .rst(rst), .set_i(cond_i), .clr_we_i(clr_we_i),
    .clr_mask_i(clr_mask_i), .take_clr_i(take_clr),
    .flags_o(flags_o), .pend_o(pend)
  );

  trap_pick #(.NA(N_A), .NB(N_B)) u_pick (
    .eff_i(eff), .hit_o(pick_hit), .lvl_o(pick_lvl),
    .num_o(pick_num), .clr_o(pick_clr)
  );

  assign hw_go    = !ret_i && pick_hit && (pick_lvl > cur_lvl);
  assign sw_go    = !ret_i && !hw_go && swt_req_i;
  assign pop      = ret_i && !stk_empty;
  assign take_clr = hw_go ? pick_clr : '0;
  assign sel_num  = hw_go ? pick_num : swt_num_i;

  lvl_stack #(.DEPTH(STK_DEPTH), .W(LVL_W)) u_stk (
    .clk(clk), .rst(rst), .push_i(hw_go), .pop_i(pop),
    .din_i(cur_lvl), .top_o(stk_top), .empty_o(stk_empty)
  );

  vec_calc #(.NUM_W(NUM_W), .OFF_W(OFF_W), .UNIT_SH(2)) u_vec (
    .num_i(sel_num), .spc_i(spc_i), .off_o(off)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_lvl <= LV_IDLE;
      take_q  <= 1'b0;
      num_q   <= '0;
      vec_q   <= '0;
    end else begin
      if (hw_go)    cur_lvl <= pick_lvl;
      else if (pop) cur_lvl <= stk_top;
      take_q <= hw_go || sw_go;
      if (hw_go || sw_go) begin
        num_q <= sel_num;
        vec_q <= {seg_i, off};
      end
    end
  end

  assign take_o = take_q;
  assign num_o  = num_q;
  assign vec_o  = vec_q;
  assign lvl_o  = cur_lvl;
endmodule

// File: rtl/trap_arbiter_chk.sv
module trap_arbiter_chk #(
  parameter int NC    = 10,
  parameter int NUM_W = 7,
  parameter int SEG_W = 8,
  parameter int OFF_W = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NC-1:0]          cond_i,
  input logic                   ret_i,
  input logic [SEG_W-1:0]       seg_i,
  input logic                   take_o,
  input logic [NUM_W-1:0]       num_o,
  input logic [SEG_W+OFF_W-1:0] vec_o,
  input logic [1:0]             lvl_o,
  input logic [NC-1:0]          flags_o
);
  localparam int AW = SEG_W + OFF_W;

  assert_flag_set_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((flags_o & $past(cond_i)) == $past(cond_i)));

  assert_hw_num_R3: assert property (@(posedge clk) disable iff (rst)
    (take_o && (lvl_o > $past(lvl_o))) |->
      (!num_o[0] && (num_o <= 7'h0A) && ((lvl_o == 2'd1) == (num_o == 7'h0A))
       && ((lvl_o == 2'd3) == (num_o == 7'h00))));

  assert_lvl_up_R5: assert property (@(posedge clk) disable iff (rst)
    (take_o && (lvl_o != $past(lvl_o))) |-> (lvl_o > $past(lvl_o)));

  assert_ret_no_take_R6: assert property (@(posedge clk) disable iff (rst)
    ret_i |=> !take_o);

  assert_sw_keep_lvl_R7: assert property (@(posedge clk) disable iff (rst)
    (take_o && num_o[0]) |-> (lvl_o == $past(lvl_o)));

  assert_vec_form_R8: assert property (@(posedge clk) disable iff (rst)
    take_o |-> ((vec_o[1:0] == 2'b00) && (vec_o[AW-1 -: SEG_W] == $past(seg_i))));
endmodule

bind trap_arbiter trap_arbiter_chk #(
  .NC(trap_pkg::N_COND), .NUM_W(trap_pkg::NUM_W), .SEG_W(SEG_W), .OFF_W(OFF_W)
) u_chk (
  .clk(clk), .rst(rst), .cond_i(cond_i), .ret_i(ret_i), .seg_i(seg_i),
  .take_o(take_o), .num_o(num_o), .vec_o(vec_o), .lvl_o(lvl_o),
  .flags_o(flags_o)
);

// File: tb/sim_trap_arbiter.sv
`timescale 1ns/1ps
module sim_trap_arbiter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  cond = '0, clr_mask = '0;
  logic        clr_we = 1'b0, swt_req = 1'b0, ret = 1'b0;
  logic [6:0]  swt_num = '0;
  logic [7:0]  seg = 8'h12;
  logic [1:0]  spc = 2'd0;
  logic        take_o;
  logic [6:0]  num_o;
  logic [23:0] vec_o;
  logic [1:0]  lvl_o;
  logic [9:0]  flags_o;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct { logic [6:0] num; logic [23:0] vec; logic [1:0] lvl; } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  trap_arbiter u0 (
    .clk(clk), .rst(rst), .cond_i(cond), .clr_we_i(clr_we), .clr_mask_i(clr_mask),
    .swt_req_i(swt_req), .swt_num_i(swt_num), .ret_i(ret), .seg_i(seg), .spc_i(spc),
    .take_o(take_o), .num_o(num_o), .vec_o(vec_o), .lvl_o(lvl_o), .flags_o(flags_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [23:0] exp_vec(input logic [6:0] n);
    int off;
    off = int'(n) * 4 * (int'(spc) + 1);
    return {seg, 16'(off)};
  endfunction

  task automatic want(input logic [6:0] n, input logic [1:0] l);
    exp_t e;
    e.num = n; e.vec = exp_vec(n); e.lvl = l;
    q.push_back(e);
  endtask

  // monitor: every take must match the next expected item
  always @(negedge clk) begin
    if (!rst && take_o) begin
      if (q.size() == 0) begin
        chk("R5", "unexpected take num", {25'd0, num_o}, 32'hFFFF_FFFF);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk("R3", "take num", {25'd0, num_o}, {25'd0, e.num});
        chk("R8", "take vec", {8'd0, vec_o}, {8'd0, e.vec});
        chk("R5", "take lvl", {30'd0, lvl_o}, {30'd0, e.lvl});
      end
    end
  end

  task automatic tick; @(negedge clk); endtask
  task automatic hw(input logic [9:0] m);
    @(negedge clk) cond = m;
    @(negedge clk) cond = '0;
  endtask
  task automatic do_ret;
    @(negedge clk) ret = 1'b1;
    @(negedge clk) ret = 1'b0;
  endtask
  task automatic sw(input logic [6:0] n);
    @(negedge clk) begin swt_req = 1'b1; swt_num = n; end
    @(negedge clk) swt_req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [9:0] fsave;
    repeat (3) tick;
    // R2 reset state
    chk("R2", "take", {31'd0, take_o}, 0);
    chk("R2", "lvl", {30'd0, lvl_o}, 0);
    chk("R2", "flags", {22'd0, flags_o}, 0);
    chk("R2", "vec", {8'd0, vec_o}, 0);
    chk("R2", "num", {25'd0, num_o}, 0);
    @(negedge clk) rst = 1'b0;
    tick;

    // R9 latency, R1 flag, class B
    want(7'h0A, 2'd1);
    hw(10'b1 << 6);
    chk("R9", "take after one edge", {31'd0, take_o}, 1);
    chk("R5", "lvl B", {30'd0, lvl_o}, 1);
    chk("R1", "flag bit6", {31'd0, flags_o[6]}, 1);
    tick;
    chk("R9", "single-cycle take", {31'd0, take_o}, 0);

    // R5 held at equal level, preempt by class A, R6 restore
    hw(10'b1 << 7);
    chk("R5", "equal level held", {31'd0, take_o}, 0);
    want(7'h04, 2'd2);
    hw(10'b1 << 2);
    do_ret;
    chk("R6", "restore lvl 1", {30'd0, lvl_o}, 1);
    chk("R6", "no take on ret", {31'd0, take_o}, 0);
    want(7'h0A, 2'd1);
    do_ret;
    chk("R6", "restore lvl 0", {30'd0, lvl_o}, 0);
    tick;
    chk("R5", "held taken after return", {31'd0, take_o}, 1);
    chk("R10", "flag bit7 kept", {31'd0, flags_o[7]}, 1);
    do_ret;

    // R10 two class-B at once: one take
    want(7'h0A, 2'd1);
    hw((10'b1 << 5) | (10'b1 << 8));
    do_ret;
    tick; tick;
    chk("R10", "no second B take", {31'd0, take_o}, 0);
    chk("R10", "both B flags", {30'd0, flags_o[8], flags_o[5]}, 3);

    // R4 class A ordering
    want(7'h02, 2'd2);
    hw((10'b1 << 1) | (10'b1 << 3) | (10'b1 << 4));
    want(7'h06, 2'd2);
    do_ret;
    tick;
    chk("R4", "second A taken", {25'd0, num_o}, 7'h06);
    want(7'h08, 2'd2);
    do_ret;
    tick;
    chk("R4", "third A taken", {25'd0, num_o}, 7'h08);
    do_ret;
    tick;
    chk("R4", "A drained", {31'd0, take_o}, 0);

    // R3 reset request preempts class A
    want(7'h04, 2'd2);
    hw(10'b1 << 2);
    want(7'h00, 2'd3);
    hw(10'b1 << 0);
    chk("R3", "reset level", {30'd0, lvl_o}, 3);
    hw(10'b1 << 1);
    chk("R5", "held under reset lvl", {31'd0, take_o}, 0);
    do_ret;
    tick;
    chk("R5", "still held at lvl 2", {31'd0, take_o}, 0);
    chk("R6", "lvl 2 restored", {30'd0, lvl_o}, 2);
    want(7'h02, 2'd2);
    do_ret;
    tick;
    do_ret;
    chk("R6", "back to idle", {30'd0, lvl_o}, 0);

    // R7 / R8 software traps
    spc = 2'd3;
    fsave = flags_o;
    want(7'h7F, 2'd0);
    sw(7'h7F);
    chk("R8", "vec max spc16", {8'd0, vec_o}, 32'h0012_07F0);
    chk("R7", "sw keeps lvl", {30'd0, lvl_o}, 0);
    chk("R7", "sw no flags", {22'd0, flags_o}, {22'd0, fsave});
    want(7'h0A, 2'd1);
    @(negedge clk) begin cond = 10'b1 << 5; swt_req = 1'b1; swt_num = 7'h33; end
    @(negedge clk) begin cond = '0; swt_req = 1'b0; end
    chk("R7", "hw wins over sw", {25'd0, num_o}, 7'h0A);
    want(7'h21, 2'd1);
    sw(7'h21);
    chk("R7", "sw at lvl1 keeps lvl", {30'd0, lvl_o}, 1);
    do_ret;
    @(negedge clk) begin ret = 1'b1; swt_req = 1'b1; swt_num = 7'h11; end
    @(negedge clk) begin ret = 1'b0; swt_req = 1'b0; end
    chk("R7", "sw dropped on ret", {31'd0, take_o}, 0);
    spc = 2'd2;
    want(7'h05, 2'd0);
    sw(7'h05);
    chk("R8", "vec spc12", {8'd0, vec_o}, 32'h0012_003C);
    spc = 2'd1; seg = 8'hA5;
    want(7'h10, 2'd0);
    sw(7'h10);
    chk("R8", "vec spc8", {8'd0, vec_o}, 32'h00A5_0080);

    // R1 clear and set-over-clear
    @(negedge clk) begin clr_we = 1'b1; clr_mask = '1; end
    @(negedge clk) clr_we = 1'b0;
    chk("R1", "flags cleared", {22'd0, flags_o}, 0);
    want(7'h0A, 2'd1);
    @(negedge clk) begin cond = 10'b1 << 9; clr_we = 1'b1; clr_mask = 10'b1 << 9; end
    @(negedge clk) begin cond = '0; clr_we = 1'b0; end
    tick; tick;
    chk("R1", "set beats clear, persists", {22'd0, flags_o}, 10'b1 << 9);
    do_ret;

    // R6 return with empty stack
    do_ret;
    chk("R6", "empty ret keeps lvl", {30'd0, lvl_o}, 0);
    tick; tick;
    chk("R5", "all expected takes seen", q.size(), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule